// File: doc/BRIEF.md
# Express Starvation Prevention Controller

At a bypass node, express flits pass straight through and always win the output they use, so a normal virtual channel sharing that output can be locked out indefinitely. This controller measures that lockout and reacts to it. Its detector half watches the normal channel's request and grant together with a flag that says whether an express flit holds the output. Once the normal channel has been refused, because of express traffic, for a set number of consecutive counted cycles, the detector emits a one-cycle token that travels upstream, against the direction of flit flow.

The suppression half sits at the upstream express source. When a token arrives, it raises an inhibit flag for a fixed number of cycles. While the flag is up, no new express packet may start. Flits of a packet already in progress are still let through so that express paths never stall mid-packet. Token transport latency and the fan-in of several upstream sources are left to the surrounding fabric: the token input is taken as already delivered.

Both halves share one top so they can be placed together or wired apart. The detector threshold `STARVE_N` and the inhibit window `INHIBIT_P` are parameters.

Top module: `evc_starve_ctrl`

## Requirements
- R1: A cycle counts as a starved cycle when `nvc_req_i`=1, `nvc_gnt_i`=0 and `evc_occ_i`=1 at the clock edge.
- R2: The starvation count returns to zero at any edge where `nvc_gnt_i`=1 or `nvc_req_i`=0. A refused cycle with `evc_occ_i`=0 leaves the count unchanged.
- R3: `token_o` is high for exactly the one cycle that follows the edge at which the STARVE_N-th counted starved cycle is sampled.
- R4: Only one token is sent per starvation episode. Further starved cycles produce no token until the count has been cleared as in R2.
- R5: An edge with `token_i`=1 makes `inhibit_o` high for exactly INHIBIT_P cycles, starting in the next cycle.
- R6: A token received while `inhibit_o` is high restarts the window, so `inhibit_o` stays high for INHIBIT_P cycles after that token.
- R7: While `inhibit_o`=1, a head flit (`evc_valid_i`=1, `evc_head_i`=1) is held back: `evc_send_o`=0.
- R8: A non-head flit (`evc_head_i`=0) passes whenever valid, inhibit or not. A head flit passes when `inhibit_o`=0. `evc_send_o` is never high without `evc_valid_i`.
- R9: While `rst_ni` is low, `token_o`=0, `inhibit_o`=0 and the starvation count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nvc_req_i | input | 1 | Normal channel requests the shared output |
| nvc_gnt_i | input | 1 | Normal channel won the output this cycle |
| evc_occ_i | input | 1 | An express flit holds the output this cycle |
| token_o | output | 1 | Starvation token pulse, sent upstream |
| token_i | input | 1 | Starvation token arriving at the express source |
| evc_valid_i | input | 1 | Express source has a flit ready to launch |
| evc_head_i | input | 1 | That flit starts a new packet |
| evc_send_o | output | 1 | Express flit may launch this cycle |
| inhibit_o | output | 1 | New express packets are suppressed |

## Verification
On every cycle, the assertions check several properties. Each token must follow a starved cycle and last a single cycle. No token may follow a grant or a dropped request. Every received token must load the full window. The inhibit flag may rise only after a token. Head flits must be held and body flits passed while inhibit is active. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle in which the token appears after STARVE_N starved cycles, and the holding of the count across refused cycles with no express occupancy. They also include the restart of a window by a second token, the one-token-per-episode rule over a long starvation, and the exact window length.

// File: rtl/evc_starve_pkg.sv
package evc_starve_pkg;

  typedef enum logic [1:0] {
    DET_IDLE  = 2'd0,
    DET_COUNT = 2'd1,
    DET_FIRED = 2'd2
  } det_state_e;

  localparam int unsigned DEF_STARVE_N  = 8;
  localparam int unsigned DEF_INHIBIT_P = 16;

endpackage

// File: rtl/evc_starve_detect.sv
module evc_starve_detect
  import evc_starve_pkg::*;
#(
  parameter int unsigned STARVE_N = DEF_STARVE_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nvc_req_i,
  input  logic nvc_gnt_i,
  input  logic evc_occ_i,
  output logic token_o
);

  localparam int unsigned CW = (STARVE_N < 2) ? 1 : $clog2(STARVE_N + 1);
  localparam logic [CW-1:0] LAST = CW'(STARVE_N - 1);

  det_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          token_q;
  logic          starved, clear, fire;

  // R1: starved cycle, R2: episode end
  assign starved = nvc_req_i & ~nvc_gnt_i & evc_occ_i;
  assign clear   = ~nvc_req_i | nvc_gnt_i;
  // R3/R4: fire once on the STARVE_N-th starved cycle
  assign fire    = starved & (state_q != DET_FIRED) & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DET_IDLE;
      cnt_q   <= '0;
      token_q <= 1'b0;
    end else begin
      token_q <= fire;
      if (clear) begin
        state_q <= DET_IDLE;
        cnt_q   <= '0;
      end else if (fire) begin
        state_q <= DET_FIRED;
      end else if (starved && state_q != DET_FIRED) begin
        state_q <= DET_COUNT;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign token_o = token_q;

  p_token_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> $past(nvc_req_i && !nvc_gnt_i && evc_occ_i));

  p_token_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> !token_o);

  p_quiet_after_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nvc_gnt_i || !nvc_req_i) |=> !token_o);

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

endmodule

// File: rtl/evc_inhibit_timer.sv
module evc_inhibit_timer
  import evc_starve_pkg::*;
#(
  parameter int unsigned INHIBIT_P = DEF_INHIBIT_P
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic token_i,
  output logic inhibit_o
);

  localparam int unsigned TW = (INHIBIT_P < 2) ? 1 : $clog2(INHIBIT_P + 1);
  localparam logic [TW-1:0] FULL = TW'(INHIBIT_P);

  logic [TW-1:0] tmr_q;

  // R5/R6: a token always reloads the full window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tmr_q <= '0;
    else if (token_i)         tmr_q <= FULL;
    else if (tmr_q != '0)     tmr_q <= tmr_q - 1'b1;
  end

  assign inhibit_o = (tmr_q != '0);

  p_token_loads_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_i |=> (inhibit_o && tmr_q == FULL));

  p_inhibit_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inhibit_o) |-> $past(token_i));

  p_tmr_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= FULL);

endmodule

// File: rtl/evc_launch_gate.sv
module evc_launch_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inhibit_i,
  input  logic evc_valid_i,
  input  logic evc_head_i,
  output logic evc_send_o
);

  // R7/R8: only packet starts are held; in-flight packets complete
  assign evc_send_o = evc_valid_i & (~evc_head_i | ~inhibit_i);

  p_head_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && evc_head_i) |-> !evc_send_o);

  p_body_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evc_valid_i && !evc_head_i) |-> evc_send_o);

  p_no_phantom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evc_send_o |-> evc_valid_i);

endmodule

// File: rtl/evc_starve_ctrl.sv
module evc_starve_ctrl
  import evc_starve_pkg::*;
#(
  parameter int unsigned STARVE_N  = DEF_STARVE_N,
  parameter int unsigned INHIBIT_P = DEF_INHIBIT_P
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nvc_req_i,
  input  logic nvc_gnt_i,
  input  logic evc_occ_i,
  output logic token_o,
  input  logic token_i,
  input  logic evc_valid_i,
  input  logic evc_head_i,
  output logic evc_send_o,
  output logic inhibit_o
);

  logic inhibit;

  evc_starve_detect #(.STARVE_N(STARVE_N)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nvc_req_i (nvc_req_i),
    .nvc_gnt_i (nvc_gnt_i),
    .evc_occ_i (evc_occ_i),
    .token_o   (token_o)
  );

  evc_inhibit_timer #(.INHIBIT_P(INHIBIT_P)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .token_i   (token_i),
    .inhibit_o (inhibit)
  );

  evc_launch_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inhibit_i   (inhibit),
    .evc_valid_i (evc_valid_i),
    .evc_head_i  (evc_head_i),
    .evc_send_o  (evc_send_o)
  );

  assign inhibit_o = inhibit;

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!token_o && !inhibit_o));

endmodule

// File: tb/evc_starve_ctrl_tb.sv
module evc_starve_ctrl_tb;

  localparam int unsigned N = 4;
  localparam int unsigned P = 5;
  localparam int NROWS = 25;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic nvc_req, nvc_gnt, evc_occ, tok_in, evc_valid, evc_head;
  logic token_o, evc_send, inhibit;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  evc_starve_ctrl #(.STARVE_N(N), .INHIBIT_P(P)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .nvc_req_i   (nvc_req),
    .nvc_gnt_i   (nvc_gnt),
    .evc_occ_i   (evc_occ),
    .token_o     (token_o),
    .token_i     (tok_in),
    .evc_valid_i (evc_valid),
    .evc_head_i  (evc_head),
    .evc_send_o  (evc_send),
    .inhibit_o   (inhibit)
  );

  // {req, gnt, occ, tok, valid, head, exp_token, exp_inhibit, exp_send}
  // expected values are those seen while the row's inputs are applied, before its edge
  localparam logic [8:0] VEC [NROWS] = '{
    9'b101_011_001, // 0  R1 count->1, head free R8
    9'b101_000_000, // 1  count->2
    9'b100_000_000, // 2  R2 no occupancy: hold 2
    9'b101_000_000, // 3  count->3
    9'b101_000_000, // 4  R3 4th starved cycle: fire
    9'b101_111_101, // 5  R3 token visible; loop back token
    9'b101_011_010, // 6  R5 inhibit, R7 head held, R4 no new token
    9'b101_010_011, // 7  R8 body passes, R4 still no token
    9'b000_000_010, // 8  R2 request drop clears
    9'b000_100_010, // 9  R6 token inside window
    9'b000_011_010, // 10 R6 reloaded
    9'b000_000_010, // 11 R6 beyond original end
    9'b000_000_010, // 12
    9'b000_000_010, // 13
    9'b000_011_010, // 14 R5 last inhibited cycle
    9'b000_011_001, // 15 R5 window over, head free
    9'b101_000_000, // 16 count->1
    9'b101_000_000, // 17 count->2
    9'b111_000_000, // 18 R2 grant clears
    9'b101_000_000, // 19 count->1
    9'b101_000_000, // 20 count->2
    9'b101_000_000, // 21 count->3
    9'b101_000_000, // 22 fire
    9'b000_000_100, // 23 R3 token after cleared restart
    9'b000_000_000  // 24 R3 one cycle only
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {nvc_req, nvc_gnt, evc_occ, tok_in, evc_valid, evc_head} = v;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive(6'b0);
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9 token", token_o, 1'b0);
    chk("R9 inhibit", inhibit, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      drive(VEC[i][8:3]);
      #1;
      chk($sformatf("R3/R4 token row %0d", i), token_o, VEC[i][2]);
      chk($sformatf("R5/R6 inhibit row %0d", i), inhibit, VEC[i][1]);
      chk($sformatf("R7/R8 send row %0d", i), evc_send, VEC[i][0]);
    end

    // R9: reset in the middle of a window and a starvation run
    @(negedge clk);
    drive(6'b101_100);
    @(negedge clk);
    drive(6'b101_011);
    #1;
    chk("R5 inhibit before reset", inhibit, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R9 inhibit in reset", inhibit, 1'b0);
    chk("R9 send head in reset", evc_send, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    // R9 count was zeroed: N-1 starved cycles must not fire
    repeat (N - 1) @(negedge clk);
    #1;
    chk("R9 count cleared by reset", token_o, 1'b0);
    @(negedge clk);
    #1;
    chk("R3 fires after N post-reset", token_o, 1'b1);

    // R8: invalid flit never sends
    drive(6'b000_001);
    #1;
    chk("R8 no send without valid", evc_send, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule